// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block is the transmit half of a low-speed FSK modem. It takes one serial data bit per sample clock and produces a stream of signed sine samples at one of two tones. The choice between the two tones follows the data bit. Two mode inputs choose among four pairs of tones. The first mode input picks the signalling standard: Bell 103 or V.21. The second picks the call role: originate or answer. No scrambling or rate conversion sits between the data bit and the tone choice. The bit selects the tone directly.

The tone comes from a numerically controlled oscillator. A 24-bit phase accumulator advances by a tuning word on every enabled sample. Each tuning word is a constant that is computed when the design is elaborated, from the tone frequency and the sample rate. The top bits of the phase address a quarter-wave sine table. The other three quadrants are obtained by mirroring and negating that table. When the data bit or the mode changes, only the tuning word changes and the accumulator keeps running, so the waveform has no phase jump. Dropping the enable clears the phase and forces the output to zero.

Top module: `fsk_tone_mod`

## Requirements
- R1: While rst_ni is low, sample_o is 0 and valid_o is 0.
- R2: A clock edge with en_i low sets sample_o to 0 and valid_o to 0 and clears the phase to 0. The first enabled sample after that therefore uses phase 0, which gives the value 6.
- R3: With std_sel_i=0 (Bell 103) and role_i=0 (originate), tx_bit_i=1 sends 1270 Hz and tx_bit_i=0 sends 1070 Hz.
- R4: With std_sel_i=0 and role_i=1 (answer), tx_bit_i=1 sends 2225 Hz and tx_bit_i=0 sends 2025 Hz.
- R5: With std_sel_i=1 (V.21) and role_i=0, tx_bit_i=1 sends 980 Hz and tx_bit_i=0 sends 1180 Hz.
- R6: With std_sel_i=1 and role_i=1, tx_bit_i=1 sends 1650 Hz and tx_bit_i=0 sends 1850 Hz.
- R7: Each enabled edge advances the 24-bit phase by round(f·2^24/9600). The same edge sets sample_o to round(2047·sin(2π(p+0.5)/1024)), where p is bits 23:14 of the phase as it stood before the edge.
- R8: A change of tx_bit_i, std_sel_i or role_i while en_i stays high changes only the phase step. The phase carries on from its current value.
- R9: valid_o is 1 one cycle after an edge with en_i high. sample_o never takes the value -2048.
- R10: The sign bit of every enabled sample equals bit 23 of the phase it was computed from. Each half-cycle is the negated mirror of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit enable |
| std_sel_i | input | 1 | 0 = Bell 103, 1 = V.21 |
| role_i | input | 1 | 0 = originate, 1 = answer |
| tx_bit_i | input | 1 | Data bit, 1 = mark, 0 = space |
| sample_o | output | 12 | Signed sine sample |
| valid_o | output | 1 | Sample strobe |

## Verification
Some rules hold on every cycle, and assertions check them continuously:
- a disabled edge zeroes both the output and the phase;
- the phase step equals the tuning word that was selected;
- the sample sign follows the top phase bit;
- the strobe follows enable;
- the most negative code never appears.

Other properties can only be shown by the bench scenarios. These are the actual tone frequency for each of the eight combinations of standard, role and bit, and the exact sample values. The bench checks them against a sine model that it computes on its own. It also checks that the phase stays continuous across bit and mode switches in the middle of a run, and that re-enabling restarts from phase zero.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  typedef enum logic { STD_BELL103 = 1'b0, STD_V21 = 1'b1 } std_e;
  typedef enum logic { ROLE_ORIG = 1'b0, ROLE_ANS = 1'b1 } role_e;

  // Tone in Hz for (standard, role, mark)
  function automatic int tone_hz(int std_v, int role_v, int mark_v);
    int f;
    if (std_v == 0) begin
      if (role_v == 0) f = (mark_v != 0) ? 1270 : 1070;
      else             f = (mark_v != 0) ? 2225 : 2025;
    end else begin
      if (role_v == 0) f = (mark_v != 0) ? 980  : 1180;
      else             f = (mark_v != 0) ? 1650 : 1850;
    end
    return f;
  endfunction

  function automatic longint tuning_word(int f, int fs, int acc_w);
    return ((longint'(f) << acc_w) + longint'(fs / 2)) / longint'(fs);
  endfunction

  // Quarter-wave entry, half-step offset keeps the mirror exact
  function automatic int quarter_sine(int a, int depth, int amp);
    real ang;
    real r;
    ang = 3.14159265358979 / 2.0 * (real'(a) + 0.5) / real'(depth);
    r   = real'(amp) * $sin(ang);
    return $rtoi(r + 0.5);
  endfunction
endpackage

// File: rtl/fsk_tone_sel.sv
module fsk_tone_sel
  import fsk_pkg::*;
#(
  parameter int SAMPLE_HZ = 9600,
  parameter int ACC_W     = 24
) (
  input  logic             std_sel_i,
  input  logic             role_i,
  input  logic             tx_bit_i,
  output logic [ACC_W-1:0] tw_o
);
  localparam int N_TONES = 8;

  logic [ACC_W-1:0] tw_tbl [N_TONES];

  for (genvar g = 0; g < N_TONES; g++) begin : g_tw
    localparam int F_HZ = tone_hz((g >> 2) & 1, (g >> 1) & 1, g & 1);
    localparam longint TW = tuning_word(F_HZ, SAMPLE_HZ, ACC_W);
    assign tw_tbl[g] = TW[ACC_W-1:0];
  end

  // Bit drives the choice directly; no scrambler in these modes
  assign tw_o = tw_tbl[{std_sel_i, role_i, tx_bit_i}];
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] tw_i,
  output logic [ACC_W-1:0] phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (!en_i) acc_q <= '0;
    else            acc_q <= acc_q + tw_i;
  end

  assign phase_o = acc_q;

  p_acc_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0);

  p_acc_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ACC_W'(acc_q - $past(acc_q)) == $past(tw_i));
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
  import fsk_pkg::*;
#(
  parameter int Q_AW  = 8,
  parameter int OUT_W = 12
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [Q_AW+1:0]         phase_i,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int DEPTH = 1 << Q_AW;
  localparam int AMP   = (1 << (OUT_W - 1)) - 1;
  localparam int PH_W  = Q_AW + 2;

  logic [OUT_W-1:0] q_tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_q
    localparam int QV = quarter_sine(g, DEPTH, AMP);
    assign q_tbl[g] = OUT_W'(QV);
  end

  logic [1:0]       quad;
  logic [Q_AW-1:0]  addr;
  logic [Q_AW-1:0]  addr_m;
  logic [OUT_W-1:0] mag;
  logic [OUT_W-1:0] val;

  always_comb begin
    quad   = phase_i[PH_W-1 -: 2];
    addr   = phase_i[Q_AW-1:0];
    addr_m = quad[0] ? ~addr : addr;
    mag    = q_tbl[addr_m];
    val    = quad[1] ? (~mag + 1'b1) : mag;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sample_o <= '0;
    else if (!en_i) sample_o <= '0;
    else            sample_o <= val;
  end

  p_sign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> sample_o[OUT_W-1] == $past(phase_i[PH_W-1]));
endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
  import fsk_pkg::*;
#(
  parameter int SAMPLE_HZ = 9600,
  parameter int ACC_W     = 24,
  parameter int Q_AW      = 8,
  parameter int OUT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             std_sel_i,
  input  logic             role_i,
  input  logic             tx_bit_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  localparam int PH_W = Q_AW + 2;

  logic [ACC_W-1:0]        tw;
  logic [ACC_W-1:0]        phase;
  logic signed [OUT_W-1:0] smp;

  fsk_tone_sel #(.SAMPLE_HZ(SAMPLE_HZ), .ACC_W(ACC_W)) u_sel (
    .std_sel_i (std_sel_i),
    .role_i    (role_i),
    .tx_bit_i  (tx_bit_i),
    .tw_o      (tw)
  );

  fsk_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tw_i    (tw),
    .phase_o (phase)
  );

  fsk_sine_lut #(.Q_AW(Q_AW), .OUT_W(OUT_W)) u_lut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .phase_i  (phase[ACC_W-1 -: PH_W]),
    .sample_o (smp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= en_i;
  end

  assign sample_o = smp;

  p_dis_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sample_o == '0) && !valid_o);

  p_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(en_i));

  p_no_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o != {1'b1, {(OUT_W-1){1'b0}}});

  initial p_rst_r1: assert (ACC_W >= PH_W);
endmodule

// File: tb/fsk_tone_mod_tb.sv
module fsk_tone_mod_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FS         = 9600;
  localparam int RUN_LEN    = 24;

  typedef struct packed {
    logic    std_v;
    logic    role_v;
    logic    bit_v;
    int      freq;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 1270}, '{1'b0, 1'b0, 1'b0, 1070},
    '{1'b0, 1'b1, 1'b1, 2225}, '{1'b0, 1'b1, 1'b0, 2025},
    '{1'b1, 1'b0, 1'b1, 980},  '{1'b1, 1'b0, 1'b0, 1180},
    '{1'b1, 1'b1, 1'b1, 1650}, '{1'b1, 1'b1, 1'b0, 1850}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        std_sel_i = 1'b0;
  logic        role_i = 1'b0;
  logic        tx_bit_i = 1'b0;
  logic [11:0] sample_o;
  logic        valid_o;

  int     n_chk = 0;
  int     n_bad = 0;
  longint acc_m = 0;
  bit     done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fsk_tone_mod u_dut (
    .clk_i, .rst_ni, .en_i, .std_sel_i, .role_i, .tx_bit_i, .sample_o, .valid_o
  );

  function automatic longint tw_of(int f);
    return ((longint'(f) << 24) + FS / 2) / FS;
  endfunction

  function automatic int sine_of(longint acc);
    int  p;
    real r;
    p = int'((acc >> 14) & 1023);
    r = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 1024.0);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  function automatic string req_of(logic s, logic r);
    case ({s, r})
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One enabled edge; compare against model, then advance model phase
  task automatic tick(string tag, int freq);
    int act;
    int exp;
    @(posedge clk_i);
    @(negedge clk_i);
    act = int'($signed(sample_o));
    exp = sine_of(acc_m);
    n_chk++;
    if ((act - exp > 1) || (exp - act > 1) || !valid_o) begin
      n_bad++;
      $display("FAIL %s/R7: actual %0d (valid %0b) expected %0d", tag, act, valid_o, exp);
    end
    check("R10 sign", int'(sample_o[11]), int'((acc_m >> 23) & 1));
    check("R9 no min", int'(sample_o == 12'h800), 0);
    acc_m = (acc_m + tw_of(freq)) & 64'hFF_FFFF;
  endtask

  task automatic disable_one();
    en_i = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2 sample off", int'(sample_o), 0);
    check("R2 valid off", int'(valid_o), 0);
    acc_m = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with enable asserted
    en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 sample", int'(sample_o), 0);
    check("R1 valid", int'(valid_o), 0);
    en_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // Table walk: each of the eight tones from phase zero
    for (int i = 0; i < 8; i++) begin
      disable_one();
      std_sel_i = VECS[i].std_v;
      role_i    = VECS[i].role_v;
      tx_bit_i  = VECS[i].bit_v;
      en_i      = 1'b1;
      for (int k = 0; k < RUN_LEN; k++)
        tick(req_of(VECS[i].std_v, VECS[i].role_v), VECS[i].freq);
    end

    // R2: first sample after re-enable comes from phase zero
    disable_one();
    std_sel_i = 1'b0; role_i = 1'b0; tx_bit_i = 1'b1; en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check("R2 restart", int'($signed(sample_o)), 6);
    acc_m = tw_of(1270);

    // R8: switches in mid-run keep the phase running
    for (int k = 0; k < 15; k++) tick("R8 mark", 1270);
    tx_bit_i = 1'b0;
    for (int k = 0; k < 15; k++) tick("R8 space", 1070);
    std_sel_i = 1'b1; role_i = 1'b1;
    for (int k = 0; k < 15; k++) tick("R8 v21 ans", 1850);
    tx_bit_i = 1'b1; role_i = 1'b0;
    for (int k = 0; k < 15; k++) tick("R8 v21 orig", 980);

    // R2 mid-run drop, then a long run covering many wraps
    disable_one();
    std_sel_i = 1'b0; role_i = 1'b1; tx_bit_i = 1'b1; en_i = 1'b1;
    for (int k = 0; k < 200; k++) tick("R4 long", 2225);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule